// File: doc/BRIEF.md
# Prescaled Up/Down/Center Timer Core

This block is a 16-bit timer core. A count-enable pulse input (`tick_i`) first passes through a programmable prescaler. The prescaler hands one step to the main counter for every P+1 accepted pulses. The counter counts up, counts down, or counts center-aligned, meaning it climbs to the reload value and then falls back to zero. At the end of every counting cycle the counter reloads from an auto-reload value. At each overflow or underflow the core raises a single-clock update pulse, which other blocks can use as a trigger. Four compare channels each hold a threshold. Each channel drives a level output that is high while the counter is below its threshold.

Software-side programming uses a single write port. The prescale and reload values are buffered. The counter only adopts them at an update event, so a running cycle always finishes with the period it started with. Compare thresholds take effect at once. Writing the force-update address applies the buffered values immediately and restarts the count.

The counter is controlled by a three-state machine:
- `S_IDLE` is the stopped state.
- `S_UP` is counting upward.
- `S_DOWN` is counting downward.

Its transitions are:
- **start**: `S_IDLE` → `S_UP` or `S_DOWN` when the run bit is set. The mode is latched here.
- **stop**: any counting state → `S_IDLE` when the run bit clears.
- **top turn**: `S_UP` → `S_DOWN` at the reload value in center mode.
- **bottom turn**: `S_DOWN` → `S_UP` at zero in center mode.
- **wrap**: same state at the period end in up or down mode.
- **force**: counting state → the state the current mode starts in.

Top module: `tmr_core`

## Requirements
- R1: After reset the counter reads 0, the direction output is 0, the update pulse is low and all compare outputs are low. The reset values are prescale 0, reload 0xFFFF and all compare thresholds 0.
- R2: With an active prescale value P, the counter advances once per P+1 cycles in which `tick_i` is high. Cycles with `tick_i` low change nothing.
- R3: Up mode (control bits [2:1] = 00, or 11) counts 0,1,…,reload and then wraps to 0.
- R4: Down mode (control bits [2:1] = 01) counts down to 0 and then wraps to the reload value. `dir_o` reads 1 while it is counting.
- R5: Center mode (control bits [2:1] = 10) counts up to the reload value, turns and counts down to 0, then turns up again. `dir_o` is 1 while falling and 0 while rising.
- R6: `upd_o` is high for exactly one clock, in the cycle in which the counter shows the value after each wrap or turn. A force update raises no pulse.
- R7: Writes to prescale (address 1) and reload (address 2) do not affect the running cycle. They take effect at the next wrap (up/down mode), at the next bottom turn (center mode), or at a force update.
- R8: Compare output i (threshold at address 3+i) is high exactly while the counter is below its threshold. A threshold of 0 keeps it low. Threshold writes apply at once.
- R9: A write to address 7 clears the prescaler count and loads both buffered values. It sets the counter to the reload value in down mode and to 0 otherwise, using the control mode field.
- R10: Control bit 0 is the run bit. While it is 0 the counter holds its value. The counting mode is latched when counting starts, so a mode written while running is ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Qualified count-enable pulse fed to the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0 control, 1 prescale, 2 reload, 3..6 thresholds, 7 force update) |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| dir_o | output | 1 | 1 while counting downward |
| upd_o | output | 1 | One-clock update/trigger pulse at each wrap or turn |
| cmp_o | output | 4 | Compare outputs, one per channel |

## Verification
The bench rewrites the reload value in the middle of a cycle and checks that the old period still completes first. A core that applied the write at once would wrap early at the new value. It drives the prescaler with gaps in `tick_i` and with a force update partway through a division. A miscounting divider would step the counter one pulse early or late, or keep a stale partial count. Center mode is checked through both turns with the exact sequence 1,2,3,2,1,0,1. An off-by-one turn would repeat the reload value or zero, or drop a pulse. The bench also writes a new mode while running and toggles the run bit. It checks that neither disturbs the count, and it checks thresholds of 0 and above the reload value on the compare outputs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_UP   = 2'd1,
        S_DOWN = 2'd2
    } state_e;

    localparam int CTRL_ADDR = 0;
    localparam int PSC_ADDR  = 1;
    localparam int ARR_ADDR  = 2;
    localparam int CMP_BASE  = 3;

    function automatic mode_e decode_mode(input logic [1:0] f);
        case (f)
            2'd1:    return MODE_DOWN;
            2'd2:    return MODE_CENTER;
            default: return MODE_UP;
        endcase
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    parameter int AW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [CW-1:0] wr_data_i,
    output logic          run_o,
    output mode_e         mode_o,
    output logic [CW-1:0] psc_sh_o,
    output logic [CW-1:0] arr_sh_o,
    output logic [CW-1:0] thr_o [NCH],
    output logic          ug_o
);

    localparam logic [AW-1:0] UG_ADDR = AW'(CMP_BASE + NCH);

    logic       run_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            mode_q   <= 2'd0;
            psc_sh_o <= '0;
            arr_sh_o <= '1;
        end else if (wr_en_i) begin
            if (wr_addr_i == AW'(CTRL_ADDR)) begin
                run_q  <= wr_data_i[0];
                mode_q <= wr_data_i[2:1];
            end
            if (wr_addr_i == AW'(PSC_ADDR)) psc_sh_o <= wr_data_i;
            if (wr_addr_i == AW'(ARR_ADDR)) arr_sh_o <= wr_data_i;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_thr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                thr_o[g] <= '0;
            else if (wr_en_i && wr_addr_i == AW'(CMP_BASE + g))
                thr_o[g] <= wr_data_i;
        end
    end

    assign run_o  = run_q;
    assign mode_o = decode_mode(mode_q);
    assign ug_o   = wr_en_i && (wr_addr_i == UG_ADDR);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [CW-1:0] psc_sh_i,
    output logic          step_o
);

    logic [CW-1:0] psc_q;
    logic [CW-1:0] pc_q;
    logic          last;

    assign last   = (pc_q >= psc_q);
    assign step_o = en_i && tick_i && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
            pc_q  <= '0;
        end else if (load_i) begin
            psc_q <= psc_sh_i;
            pc_q  <= '0;
        end else if (en_i && tick_i) begin
            pc_q <= last ? '0 : pc_q + CW'(1);
        end
    end

    // R2: after a step the division restarts, so a divisor above one forbids a back-to-back step
    a_r2_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !load_i && psc_q != '0) |=> !step_o)
        else $error("a_r2_step_spacing");

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  mode_e         mode_i,
    input  logic          step_i,
    input  logic          ug_i,
    input  logic [CW-1:0] arr_sh_i,
    output logic [CW-1:0] cnt_o,
    output logic          dir_o,
    output logic          upd_o,
    output logic          en_o,
    output logic          load_o
);

    state_e        state_q, state_d;
    mode_e         mode_q, mode_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] arr_q;
    logic          upd_q;
    logic          ev, top;

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        cnt_d   = cnt_q;
        ev      = 1'b0;
        top     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (run_i) begin
                    mode_d  = mode_i;
                    state_d = (mode_i == MODE_DOWN) ? S_DOWN : S_UP;
                end
            end
            S_UP: begin
                if (!run_i) begin
                    state_d = S_IDLE;
                end else if (step_i) begin
                    if (cnt_q >= arr_q) begin
                        ev = 1'b1;
                        if (mode_q == MODE_CENTER) begin
                            top     = 1'b1;
                            state_d = S_DOWN;
                            cnt_d   = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
                        end else begin
                            cnt_d = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            S_DOWN: begin
                if (!run_i) begin
                    state_d = S_IDLE;
                end else if (step_i) begin
                    if (cnt_q == '0) begin
                        ev = 1'b1;
                        if (mode_q == MODE_CENTER) begin
                            state_d = S_UP;
                            cnt_d   = (arr_sh_i == '0) ? '0 : CW'(1);
                        end else begin
                            cnt_d = arr_sh_i;
                        end
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (ug_i) begin
            ev    = 1'b0;
            top   = 1'b0;
            cnt_d = (mode_i == MODE_DOWN) ? arr_sh_i : '0;
            if (state_d != S_IDLE) begin
                mode_d  = mode_i;
                state_d = (mode_i == MODE_DOWN) ? S_DOWN : S_UP;
            end
        end
    end

    assign load_o = ug_i || (ev && !top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= MODE_UP;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            arr_q <= '1;
            upd_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            upd_q <= ev;
            if (load_o) arr_q <= arr_sh_i;
        end
    end

    assign cnt_o = cnt_q;
    assign dir_o = (state_q == S_DOWN);
    assign upd_o = upd_q;
    assign en_o  = (state_q != S_IDLE);

    // R6: an update pulse only follows a prescaler step
    a_r6_upd_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> $past(step_i))
        else $error("a_r6_upd_after_step");

    // R7: the counter never runs past the period in force
    a_r7_cnt_within_reload: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= arr_q)
        else $error("a_r7_cnt_within_reload");

    // R10: stopped counter holds unless forced
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !ug_i) |=> (cnt_q == $past(cnt_q)))
        else $error("a_r10_idle_hold");

    // R5: every center-mode direction turn comes with an update pulse
    a_r5_turn_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CENTER && state_q != S_IDLE && $past(state_q) != S_IDLE
         && state_q != $past(state_q) && !$past(ug_i)) |-> upd_q)
        else $error("a_r5_turn_pulses");

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic [CW-1:0]  cnt_i,
    input  logic [CW-1:0]  thr_i [NCH],
    output logic [NCH-1:0] cmp_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cmp_o[g] = (cnt_i < thr_i[g]);
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    localparam int AW = $clog2(CMP_BASE + NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [CW-1:0]  wr_data_i,
    output logic [CW-1:0]  cnt_o,
    output logic           dir_o,
    output logic           upd_o,
    output logic [NCH-1:0] cmp_o
);

    logic          run;
    mode_e         mode;
    logic [CW-1:0] psc_sh, arr_sh;
    logic [CW-1:0] thr [NCH];
    logic          ug, step, en, load;

    tmr_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .run_o     (run),
        .mode_o    (mode),
        .psc_sh_o  (psc_sh),
        .arr_sh_o  (arr_sh),
        .thr_o     (thr),
        .ug_o      (ug)
    );

    tmr_prescaler #(.CW(CW)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .tick_i   (tick_i),
        .load_i   (load),
        .psc_sh_i (psc_sh),
        .step_o   (step)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .mode_i   (mode),
        .step_i   (step),
        .ug_i     (ug),
        .arr_sh_i (arr_sh),
        .cnt_o    (cnt_o),
        .dir_o    (dir_o),
        .upd_o    (upd_o),
        .en_o     (en),
        .load_o   (load)
    );

    tmr_compare #(.CW(CW), .NCH(NCH)) u_cmp (
        .cnt_i (cnt_o),
        .thr_i (thr),
        .cmp_o (cmp_o)
    );

endmodule

// File: tb/tmr_core_tb.sv
module tmr_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] cnt_o;
    logic        dir_o, upd_o;
    logic [3:0]  cmp_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] thr_m [4];

    always #5 clk = ~clk;

    tmr_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
        .dir_o(dir_o), .upd_o(upd_o), .cmp_o(cmp_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en_i   = 1'b1;
        wr_addr_i = 3'(addr);
        wr_data_i = 16'(data);
        tick_i    = 1'b0;
        @(negedge clk);
        wr_en_i   = 1'b0;
        if (addr >= 3 && addr <= 6) thr_m[addr-3] = 16'(data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tk(input int exp_cnt, input int exp_upd, input string tag);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk({tag, " cnt"}, int'(cnt_o), exp_cnt);
        chk({tag, " upd"}, int'(upd_o), exp_upd);
    endtask

    task automatic chk_cmp(input string tag);
        logic [3:0] e;
        for (int i = 0; i < 4; i++) e[i] = (cnt_o < thr_m[i]);
        chk(tag, int'(cmp_o), int'(e));
    endtask

    task automatic t_reset();
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 dir", int'(dir_o), 0);
        chk("R1 upd", int'(upd_o), 0);
        chk("R1 cmp", int'(cmp_o), 0);
    endtask

    task automatic t_up();
        wr(2, 4);
        wr(7, 0);
        chk("R9 force to zero", int'(cnt_o), 0);
        chk("R6 no pulse on force", int'(upd_o), 0);
        wr(0, 1);
        idle(1);
        tk(1, 0, "R3 up");
        tk(2, 0, "R3 up");
        tk(3, 0, "R3 up");
        tk(4, 0, "R3 up");
        tk(0, 1, "R3 R6 wrap");
        idle(1);
        chk("R6 one clock", int'(upd_o), 0);
        tk(1, 0, "R3 after wrap");
    endtask

    task automatic t_shadow();
        wr(2, 2);
        tk(2, 0, "R7 old period");
        tk(3, 0, "R7 old period");
        tk(4, 0, "R7 old period");
        tk(0, 1, "R7 wrap old");
        tk(1, 0, "R7 new period");
        tk(2, 0, "R7 new period");
        tk(0, 1, "R7 wrap new");
    endtask

    task automatic t_compare();
        wr(3, 2); wr(4, 0); wr(5, 9); wr(6, 1);
        chk_cmp("R8 cnt0");
        chk("R8 zero threshold low", int'(cmp_o[1]), 0);
        tk(1, 0, "R8 step");
        chk_cmp("R8 cnt1");
        tk(2, 0, "R8 step");
        chk_cmp("R8 cnt2");
        tk(0, 1, "R8 wrap");
        chk_cmp("R8 cnt0 again");
    endtask

    task automatic t_stop_latch();
        wr(0, 3);
        tk(1, 0, "R10 mode latched");
        chk("R10 dir stays up", int'(dir_o), 0);
        wr(0, 0);
        idle(1);
        tk(1, 0, "R10 stopped");
        tk(1, 0, "R10 stopped");
    endtask

    task automatic t_down();
        wr(2, 3);
        wr(0, 2);
        wr(7, 0);
        chk("R9 force to reload", int'(cnt_o), 3);
        wr(0, 3);
        idle(1);
        chk("R4 dir", int'(dir_o), 1);
        tk(2, 0, "R4 down");
        tk(1, 0, "R4 down");
        tk(0, 0, "R4 down");
        tk(3, 1, "R4 R6 underflow");
        chk("R4 dir after wrap", int'(dir_o), 1);
    endtask

    task automatic t_center();
        wr(0, 4);
        idle(1);
        wr(7, 0);
        chk("R9 center force", int'(cnt_o), 0);
        wr(0, 5);
        idle(1);
        tk(1, 0, "R5 rise"); chk("R5 dir", int'(dir_o), 0);
        tk(2, 0, "R5 rise");
        tk(3, 0, "R5 rise");
        tk(2, 1, "R5 top turn"); chk("R5 dir", int'(dir_o), 1);
        tk(1, 0, "R5 fall");
        tk(0, 0, "R5 fall");
        tk(1, 1, "R5 bottom turn"); chk("R5 dir", int'(dir_o), 0);
    endtask

    task automatic t_prescale();
        wr(0, 0);
        idle(1);
        wr(1, 2);
        wr(2, 4);
        wr(7, 0);
        wr(0, 1);
        idle(1);
        tk(0, 0, "R2 divide");
        tk(0, 0, "R2 divide");
        tk(1, 0, "R2 third pulse");
        idle(3);
        chk("R2 no tick hold", int'(cnt_o), 1);
        wr(1, 0);
        tk(1, 0, "R7 prescale buffered");
        tk(1, 0, "R7 prescale buffered");
        tk(2, 0, "R7 prescale buffered");
        tk(2, 0, "R9 partial count");
        wr(7, 0);
        chk("R9 force clears", int'(cnt_o), 0);
        tk(1, 0, "R9 shadow prescale loaded");
        tk(2, 0, "R9 shadow prescale loaded");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) thr_m[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_up();
        t_shadow();
        t_compare();
        t_stop_latch();
        t_down();
        t_center();
        t_prescale();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule